// File: doc/BRIEF.md
# Narrow/Wide Data Lane Steering

This block sits between a byte-oriented internal transfer path and a parallel bus that carries one or two byte lanes per transfer, each lane with its own odd parity bit. A mode input selects 8-bit or 16-bit operation. The width setting applies only while the bus is in a data phase. Command, status and message phases always move single bytes on the low lane.

On the transmit side, a valid/ready byte stream is packed into bus transfers. In wide data phases two bytes form one word; otherwise each byte becomes one transfer with the high lane released. On the receive side, each captured bus word is unpacked into a byte stream, and the lane parity is checked.

A transfer can end after only the low byte of a wide word has been consumed. In that case the leftover high byte moves into a residual holding register and a flag marks it valid. Reading the residual register clears the flag. Dropping the wide mode also clears the flag.

Top module: `bus_lane_steer`

## Requirements
- R1: With the wide mode off, each byte accepted on `tx_byte` produces one bus transfer. `bus_tx_strobe` is high for exactly the cycle after acceptance, and the byte is on `bus_tx_data[7:0]`.
- R2: With the wide mode on in a data phase (phase code 2'b00), two accepted bytes form one transfer in the cycle after the second byte. The first byte goes on bits 7:0 and the second on bits 15:8. No strobe follows the first byte.
- R3: In command (2'b01), status (2'b10) and message (2'b11) phases, every byte is sent as a narrow transfer whatever the wide mode says.
- R4: In every narrow transmit transfer, the high lane is driven to 8'hFF and the lane-1 parity bit to 1. After reset, `bus_tx_data` is 16'hFFFF and `bus_tx_par` is 2'b11.
- R5: Each transmitted lane carries odd parity: the byte together with its parity bit holds an odd number of ones.
- R6: In a wide data phase, a byte accepted with `tx_last` high and no byte pending is sent at once as a transfer with the high lane released.
- R7: With the wide mode off, or outside data phases, a captured bus word yields one byte, taken from the low lane. The high lane and its parity bit are ignored and never raise a parity error.
- R8: In a wide data phase, a captured word yields the low byte and then the high byte on `rx_byte`. `bus_rx_ready` stays low until both have been consumed.
- R9: `rx_par_err[n]` pulses for one cycle, in the cycle after capture, when checked lane n holds an even number of ones counting its parity bit.
- R10: If `rx_end` is high while only the high byte of a wide word remains and it is not consumed, that byte moves to `resid_byte`. `resid_flag` is set in the next cycle and `rx_valid` drops.
- R11: `resid_rd` clears `resid_flag` in the next cycle, and `resid_byte` keeps its value.
- R12: While the wide mode is off, `resid_flag` is cleared in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_en | input | 1 | Wide (16-bit) data mode select |
| bus_phase | input | 2 | Phase code: 00 data, 01 command, 10 status, 11 message |
| tx_byte | input | 8 | Transmit byte from the internal path |
| tx_valid | input | 1 | Transmit byte valid |
| tx_last | input | 1 | Marks the last byte of a transmit transfer |
| tx_ready | output | 1 | Transmit byte accepted (always high) |
| bus_tx_data | output | 16 | Bus data driven out, both lanes |
| bus_tx_par | output | 2 | Odd parity per transmit lane |
| bus_tx_strobe | output | 1 | One-cycle pulse per bus transfer |
| bus_rx_data | input | 16 | Bus data received, both lanes |
| bus_rx_par | input | 2 | Received parity per lane |
| bus_rx_strobe | input | 1 | A received bus word is present |
| bus_rx_ready | output | 1 | Block can capture a received word |
| rx_byte | output | 8 | Received byte to the internal path |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Internal path takes the received byte |
| rx_end | input | 1 | Receive transfer ends |
| rx_par_err | output | 2 | Per-lane receive parity error pulse |
| resid_rd | input | 1 | Read of the residual byte |
| resid_byte | output | 8 | Residual held byte |
| resid_flag | output | 1 | Residual byte valid |

## Verification
A corrupted pending-byte state on transmit shows up on the strobe of the next accepted byte. It appears as a missing strobe, an extra strobe, or bytes swapped between lanes, exactly one cycle after acceptance. A wrong receive unpack state shows on `rx_byte` or `bus_rx_ready` in the cycle after capture or consumption. A residual flag that is stale or missing shows up one cycle after `rx_end`, `resid_rd` or the wide mode dropping. Parity faults are visible as a missing or misplaced one-cycle pulse on `rx_par_err`, which makes the lane-1 suppression in narrow mode directly observable.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

  typedef enum logic [1:0] {
    PH_DATA = 2'b00,
    PH_CMD  = 2'b01,
    PH_STAT = 2'b10,
    PH_MSG  = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    RX_EMPTY  = 2'b00,
    RX_NARROW = 2'b01,
    RX_LO     = 2'b10,
    RX_HI     = 2'b11
  } rx_state_e;

  // width setting only matters in data phases
  function automatic logic wide_active(input logic wide_en, input logic [1:0] phase);
    return wide_en && (phase == PH_DATA);
  endfunction

endpackage

// File: rtl/lane_tx_pack.sv
module lane_tx_pack
  import lane_steer_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_en,
  input  logic [1:0]          bus_phase,
  input  logic [LANE_W-1:0]   tx_byte,
  input  logic                tx_valid,
  input  logic                tx_last,
  output logic [2*LANE_W-1:0] bus_tx_data,
  output logic [1:0]          bus_tx_par,
  output logic                bus_tx_strobe
);
  localparam int BUS_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] REL = {LANE_W{1'b1}};
  localparam logic REL_PAR = ~^REL;

  logic              pend_q;
  logic [LANE_W-1:0] lo_q;
  logic              wide_now;

  assign wide_now = wide_active(wide_en, bus_phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= 1'b0;
      lo_q          <= '0;
      bus_tx_strobe <= 1'b0;
      bus_tx_data   <= {REL, REL};
      bus_tx_par    <= {REL_PAR, REL_PAR};
    end else begin
      bus_tx_strobe <= 1'b0;
      if (tx_valid) begin
        if (pend_q) begin
          bus_tx_data   <= {tx_byte, lo_q};
          bus_tx_par    <= {~^tx_byte, ~^lo_q};
          bus_tx_strobe <= 1'b1;
          pend_q        <= 1'b0;
        end else if (wide_now && !tx_last) begin
          lo_q   <= tx_byte;
          pend_q <= 1'b1;
        end else begin
          bus_tx_data   <= {REL, tx_byte};
          bus_tx_par    <= {REL_PAR, ~^tx_byte};
          bus_tx_strobe <= 1'b1;
        end
      end
    end
  end

  AST_CTRL_PHASE_NARROW: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !pend_q && bus_phase != PH_DATA) |=>
      (bus_tx_strobe && bus_tx_data[BUS_W-1:LANE_W] == REL)) else $error("narrow"); // R3
  AST_TX_LANE0_ODD: assert property (@(posedge clk) disable iff (rst)
    bus_tx_strobe |-> (^{bus_tx_data[LANE_W-1:0], bus_tx_par[0]})) else $error("par0"); // R5
  AST_TX_LANE1_ODD: assert property (@(posedge clk) disable iff (rst)
    bus_tx_strobe |-> (^{bus_tx_data[BUS_W-1:LANE_W], bus_tx_par[1]})) else $error("par1"); // R5
  AST_WIDE_HIGH_BYTE: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && pend_q) |=>
      (bus_tx_strobe && bus_tx_data[BUS_W-1:LANE_W] == $past(tx_byte))) else $error("hi"); // R2

endmodule

// File: rtl/lane_rx_unpack.sv
module lane_rx_unpack
  import lane_steer_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_en,
  input  logic [1:0]          bus_phase,
  input  logic [2*LANE_W-1:0] bus_rx_data,
  input  logic [1:0]          bus_rx_par,
  input  logic                bus_rx_strobe,
  output logic                bus_rx_ready,
  output logic [LANE_W-1:0]   rx_byte,
  output logic                rx_valid,
  input  logic                rx_ready,
  input  logic                rx_end,
  output logic [1:0]          rx_par_err,
  output logic                store_en,
  output logic [LANE_W-1:0]   store_byte
);
  localparam int BUS_W = 2 * LANE_W;

  rx_state_e         st_q;
  logic [LANE_W-1:0] lo_q, hi_q;
  logic              cap, wide_cap, take;

  assign bus_rx_ready = (st_q == RX_EMPTY);
  assign cap          = bus_rx_strobe && bus_rx_ready;
  assign wide_cap     = wide_active(wide_en, bus_phase);
  assign rx_valid     = (st_q != RX_EMPTY);
  assign rx_byte      = (st_q == RX_HI) ? hi_q : lo_q;
  assign take         = rx_valid && rx_ready;
  assign store_en     = (st_q == RX_HI) && rx_end && !rx_ready;
  assign store_byte   = hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RX_EMPTY;
      lo_q       <= '0;
      hi_q       <= '0;
      rx_par_err <= 2'b00;
    end else begin
      rx_par_err <= 2'b00;
      if (cap) begin
        lo_q          <= bus_rx_data[LANE_W-1:0];
        hi_q          <= bus_rx_data[BUS_W-1:LANE_W];
        st_q          <= wide_cap ? RX_LO : RX_NARROW;
        rx_par_err[0] <= ~^{bus_rx_data[LANE_W-1:0], bus_rx_par[0]};
        rx_par_err[1] <= wide_cap && ~^{bus_rx_data[BUS_W-1:LANE_W], bus_rx_par[1]};
      end else if (take) begin
        st_q <= (st_q == RX_LO) ? RX_HI : RX_EMPTY;
      end else if (rx_end) begin
        st_q <= RX_EMPTY;
      end
    end
  end

  AST_LANE1_QUIET_NARROW: assert property (@(posedge clk) disable iff (rst)
    (cap && !wide_cap) |=> !rx_par_err[1]) else $error("lane1 err"); // R7
  AST_LOW_BYTE_FIRST: assert property (@(posedge clk) disable iff (rst)
    cap |=> (rx_valid && rx_byte == $past(bus_rx_data[LANE_W-1:0]))) else $error("low first"); // R8
  AST_HIGH_BYTE_SECOND: assert property (@(posedge clk) disable iff (rst)
    (take && st_q == RX_LO) |=> (rx_valid && !bus_rx_ready)) else $error("high second"); // R8

endmodule

// File: rtl/lane_resid_hold.sv
module lane_resid_hold #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_en,
  input  logic              store_en,
  input  logic [LANE_W-1:0] store_byte,
  input  logic              resid_rd,
  output logic [LANE_W-1:0] resid_byte,
  output logic              resid_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      resid_flag <= 1'b0;
      resid_byte <= '0;
    end else begin
      if (store_en) resid_byte <= store_byte;
      if (!wide_en)      resid_flag <= 1'b0;
      else if (store_en) resid_flag <= 1'b1;
      else if (resid_rd) resid_flag <= 1'b0;
    end
  end

  AST_NARROW_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !wide_en |=> !resid_flag) else $error("flag kept"); // R12
  AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (resid_rd && !store_en) |=> (!resid_flag && $stable(resid_byte))) else $error("rd"); // R11
  AST_STORE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (store_en && wide_en) |=> (resid_flag && resid_byte == $past(store_byte))) else $error("st"); // R10

endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
  import lane_steer_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_en,
  input  logic [1:0]          bus_phase,
  input  logic [LANE_W-1:0]   tx_byte,
  input  logic                tx_valid,
  input  logic                tx_last,
  output logic                tx_ready,
  output logic [2*LANE_W-1:0] bus_tx_data,
  output logic [1:0]          bus_tx_par,
  output logic                bus_tx_strobe,
  input  logic [2*LANE_W-1:0] bus_rx_data,
  input  logic [1:0]          bus_rx_par,
  input  logic                bus_rx_strobe,
  output logic                bus_rx_ready,
  output logic [LANE_W-1:0]   rx_byte,
  output logic                rx_valid,
  input  logic                rx_ready,
  input  logic                rx_end,
  output logic [1:0]          rx_par_err,
  input  logic                resid_rd,
  output logic [LANE_W-1:0]   resid_byte,
  output logic                resid_flag
);

  logic              store_en;
  logic [LANE_W-1:0] store_byte;

  assign tx_ready = 1'b1;

  lane_tx_pack #(.LANE_W(LANE_W)) u_tx (
    .clk(clk), .rst(rst), .wide_en(wide_en), .bus_phase(bus_phase),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_last(tx_last),
    .bus_tx_data(bus_tx_data), .bus_tx_par(bus_tx_par), .bus_tx_strobe(bus_tx_strobe)
  );

  lane_rx_unpack #(.LANE_W(LANE_W)) u_rx (
    .clk(clk), .rst(rst), .wide_en(wide_en), .bus_phase(bus_phase),
    .bus_rx_data(bus_rx_data), .bus_rx_par(bus_rx_par), .bus_rx_strobe(bus_rx_strobe),
    .bus_rx_ready(bus_rx_ready), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_end(rx_end), .rx_par_err(rx_par_err),
    .store_en(store_en), .store_byte(store_byte)
  );

  lane_resid_hold #(.LANE_W(LANE_W)) u_resid (
    .clk(clk), .rst(rst), .wide_en(wide_en), .store_en(store_en),
    .store_byte(store_byte), .resid_rd(resid_rd),
    .resid_byte(resid_byte), .resid_flag(resid_flag)
  );

  AST_TX_STROBE_FOLLOWS_NARROW: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !wide_en && !$past(tx_valid && wide_en)) |=> bus_tx_strobe) else $error("strobe"); // R1

endmodule

// File: tb/bus_lane_steer_test.sv
module bus_lane_steer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide_en = 1'b0;
  logic [1:0] bus_phase = 2'b00;
  logic [7:0] tx_byte = 8'h00;
  logic tx_valid = 1'b0, tx_last = 1'b0;
  logic tx_ready;
  logic [15:0] bus_tx_data;
  logic [1:0] bus_tx_par;
  logic bus_tx_strobe;
  logic [15:0] bus_rx_data = 16'h0000;
  logic [1:0] bus_rx_par = 2'b00;
  logic bus_rx_strobe = 1'b0;
  logic bus_rx_ready;
  logic [7:0] rx_byte;
  logic rx_valid;
  logic rx_ready = 1'b0, rx_end = 1'b0;
  logic [1:0] rx_par_err;
  logic resid_rd = 1'b0;
  logic [7:0] resid_byte;
  logic resid_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_lane_steer uut (.*);

  function automatic logic op(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R4 reset data", bus_tx_data, 16'hFFFF);
    chk("R4 reset par", bus_tx_par, 2'b11);
    chk("R1 reset strobe", bus_tx_strobe, 0);
    chk("R8 reset rx", {rx_valid, bus_rx_ready}, 2'b01);
    chk("R10 reset flag", resid_flag, 0);
  endtask

  task automatic t_tx_narrow();
    wide_en = 0; bus_phase = 2'b00;
    tx_valid = 1; tx_byte = 8'hA5; step();
    chk("R1 strobe", bus_tx_strobe, 1);
    chk("R4 narrow data", bus_tx_data, 16'hFFA5);
    chk("R5 narrow par", bus_tx_par, {1'b1, op(8'hA5)});
    tx_byte = 8'h07; step();
    chk("R1 back-to-back", {bus_tx_strobe, bus_tx_data}, {1'b1, 16'hFF07});
    chk("R5 par 07", bus_tx_par[0], op(8'h07));
    tx_valid = 0; step();
    chk("R1 single pulse", bus_tx_strobe, 0);
  endtask

  task automatic t_tx_wide();
    wide_en = 1; bus_phase = 2'b00;
    tx_valid = 1; tx_byte = 8'h3C; step();
    chk("R2 no strobe on first", bus_tx_strobe, 0);
    tx_byte = 8'hC1; step();
    chk("R2 word", {bus_tx_strobe, bus_tx_data}, {1'b1, 16'hC13C});
    chk("R5 wide par", bus_tx_par, {op(8'hC1), op(8'h3C)});
    tx_valid = 0; step();
    chk("R2 pulse ends", bus_tx_strobe, 0);
  endtask

  task automatic t_tx_ctrl_phase();
    wide_en = 1;
    for (int p = 1; p < 4; p++) begin
      bus_phase = p[1:0];
      tx_valid = 1; tx_byte = 8'h10 + 8'(p); step();
      chk("R3 ctrl phase narrow", {bus_tx_strobe, bus_tx_data}, {1'b1, 8'hFF, 8'h10 + 8'(p)});
    end
    tx_valid = 0; bus_phase = 2'b00; step();
  endtask

  task automatic t_tx_last();
    wide_en = 1; bus_phase = 2'b00;
    tx_valid = 1; tx_last = 1; tx_byte = 8'h77; step();
    chk("R6 lone byte", {bus_tx_strobe, bus_tx_data}, {1'b1, 16'hFF77});
    chk("R6 released par", bus_tx_par[1], 1'b1);
    tx_valid = 0; tx_last = 0; step();
  endtask

  task automatic t_rx_narrow();
    wide_en = 0; bus_phase = 2'b00;
    bus_rx_data = 16'h0081; bus_rx_par = {1'b0, op(8'h81)}; bus_rx_strobe = 1; step();
    bus_rx_strobe = 0;
    chk("R7 byte", {rx_valid, rx_byte}, {1'b1, 8'h81});
    chk("R7 lane1 ignored", rx_par_err, 2'b00);
    chk("R7 busy", bus_rx_ready, 0);
    rx_ready = 1; step(); rx_ready = 0;
    chk("R7 drained", {rx_valid, bus_rx_ready}, 2'b01);
  endtask

  task automatic t_rx_wide();
    wide_en = 1; bus_phase = 2'b00;
    bus_rx_data = 16'hB24D; bus_rx_par = {op(8'hB2), op(8'h4D)}; bus_rx_strobe = 1; step();
    bus_rx_strobe = 0;
    chk("R8 low first", {rx_valid, rx_byte, bus_rx_ready}, {1'b1, 8'h4D, 1'b0});
    chk("R9 clean", rx_par_err, 2'b00);
    rx_ready = 1; step();
    chk("R8 high second", {rx_valid, rx_byte, bus_rx_ready}, {1'b1, 8'hB2, 1'b0});
    step(); rx_ready = 0;
    chk("R8 empty", {rx_valid, bus_rx_ready}, 2'b01);
  endtask

  task automatic t_rx_parity();
    wide_en = 1; bus_phase = 2'b00;
    bus_rx_data = 16'h1122; bus_rx_par = {~op(8'h11), op(8'h22)}; bus_rx_strobe = 1; step();
    bus_rx_strobe = 0;
    chk("R9 lane1 err", rx_par_err, 2'b10);
    step();
    chk("R9 pulse ends", rx_par_err, 2'b00);
    rx_end = 1; step(); rx_end = 0;
    bus_rx_data = 16'h1122; bus_rx_par = {op(8'h11), ~op(8'h22)}; bus_rx_strobe = 1; step();
    bus_rx_strobe = 0;
    chk("R9 lane0 err", rx_par_err, 2'b01);
    rx_end = 1; step(); rx_end = 0;
  endtask

  task automatic t_residual();
    wide_en = 1; bus_phase = 2'b00;
    bus_rx_data = 16'hE11E; bus_rx_par = {op(8'hE1), op(8'h1E)}; bus_rx_strobe = 1; step();
    bus_rx_strobe = 0;
    rx_ready = 1; step(); rx_ready = 0;
    rx_end = 1; step(); rx_end = 0;
    chk("R10 flag set", {resid_flag, resid_byte}, {1'b1, 8'hE1});
    chk("R10 stream empty", rx_valid, 0);
    resid_rd = 1; step(); resid_rd = 0;
    chk("R11 read clears", {resid_flag, resid_byte}, {1'b0, 8'hE1});
    bus_rx_data = 16'h5AA5; bus_rx_par = {op(8'h5A), op(8'hA5)}; bus_rx_strobe = 1; step();
    bus_rx_strobe = 0;
    rx_ready = 1; step(); rx_ready = 0;
    rx_end = 1; step(); rx_end = 0;
    chk("R10 second store", {resid_flag, resid_byte}, {1'b1, 8'h5A});
    wide_en = 0; step();
    chk("R12 mode off clears", resid_flag, 0);
    wide_en = 1; step();
    chk("R12 stays clear", resid_flag, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step(); rst = 0; step();
    t_reset();
    t_tx_narrow();
    t_tx_wide();
    t_tx_ctrl_phase();
    t_tx_last();
    t_rx_narrow();
    t_rx_wide();
    t_rx_parity();
    t_residual();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule